// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight level-sensitive interrupt requests and holds them in a pending register. A per-level mask removes levels from consideration. The remaining requests are ranked under one of four priority schemes, and the block drives a single interrupt line toward the processor. The processor accepts the interrupt with an acknowledge strobe and receives a vector number in the same cycle. When service is finished, it issues an end-of-interrupt strobe.

Software configures the block through a small write-only register bus with four registers:

| Address | Register | Bits used |
|---|---|---|
| 0 | Priority scheme | bits 1:0 (00 fixed, 01 rotate-on-service, 10 software-chosen bottom, 11 polled) |
| 1 | Mask byte | bit n set masks level n |
| 2 | Bottom level | bits 2:0 |
| 3 | Vector base | bits 7:3 |

A register write takes effect from the next clock cycle. The scheme can be changed while requests are outstanding.

In polled mode the interrupt line stays low. Software instead reads a status byte that names the highest-ranked pending unmasked request.

The ack, poll_rd and eoi strobes are single-cycle commands. Each response (vec_out or poll_status) is valid during the same cycle as its strobe. There is no back-pressure: the consumer must take the response in that cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_out is low, the scheme is fixed, the mask is clear, the pending and in-service registers are empty, the bottom level is 7 and the vector base is 0.
- R2: In the fixed scheme, level 0 ranks highest and level 7 lowest. irq_out rises in the cycle after a request is latched.
- R3: A mask write with bit n set prevents level n from raising irq_out and from appearing in the polled status. Clearing the bit lets a pending request through again.
- R4: A pending unmasked request raises irq_out only if its rank is strictly higher than every in-service level.
- R5: An acknowledge while irq_out is high clears the winning bit from the pending register and sets it in the in-service register. It returns vec_out = {base[7:3], level}. An acknowledge while irq_out is low returns {base[7:3], 3'd7} and changes no state.
- R6: An end-of-interrupt strobe clears the highest-ranked in-service bit.
- R7: In the rotate-on-service scheme, an end-of-interrupt also makes the level it cleared the bottom level. The level one above it becomes the highest.
- R8: In the software-chosen-bottom scheme, the level written at address 2 ranks lowest. Ranks ascend cyclically from the level above it.
- R9: In the polled scheme, irq_out stays low. poll_status holds bit 7 = any unmasked request pending, bits 6:3 = 0 and bits 2:0 = winning level. A poll read with bit 7 set acts as an acknowledge of that level. Polling ranks requests without regard to the in-service register.
- R10: A scheme or bottom-level write applies to the arbitration of the very next cycle, even with requests outstanding.
- R11: A request held for a single cycle stays pending until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Level-sensitive request per level |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0 scheme, 1 mask, 2 bottom level, 3 vector base) |
| cfg_wdata | input | 8 | Register write data |
| ack | input | 1 | Interrupt acknowledge strobe |
| eoi | input | 1 | Non-specific end-of-interrupt strobe |
| poll_rd | input | 1 | Polled status read strobe |
| irq_out | output | 1 | Interrupt to the processor |
| vec_out | output | 8 | Vector number, valid in the ack cycle |
| poll_status | output | 8 | Polled status byte, valid in the poll_rd cycle |

## Verification
The embedded assertions check the following on every cycle:
- a latched request persists;
- a taken acknowledge lands its level in the in-service register;
- an end-of-interrupt removes exactly one in-service bit;
- a mask write is stored;
- a write selecting polled mode silences the interrupt line.

Other properties only the bench's scenarios can show. These are:
- the ranking order under each scheme;
- the rotation of the bottom level after service;
- in-service blocking of lower-ranked requests;
- the vector and status encodings.

The bench shows these by comparing every cycle against a reference model, across directed cases and seeded random traffic that changes scheme at run time.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SCH_FIXED  = 2'd0,
    SCH_ROTATE = 2'd1,
    SCH_BOTTOM = 2'd2,
    SCH_POLLED = 2'd3
  } pic_sched_e;

  localparam logic [1:0] REG_SCHED = 2'd0;
  localparam logic [1:0] REG_MASK  = 2'd1;
  localparam logic [1:0] REG_LOW   = 2'd2;
  localparam logic [1:0] REG_BASE  = 2'd3;
endpackage

// File: rtl/pic_pick.sv
// Cyclic priority picker: the level just above 'low' ranks first.
module pic_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] low,
  output logic          found,
  output logic [LW-1:0] lvl,
  output logic [LW-1:0] rank
);
  logic [LW-1:0] idx;

  always_comb begin
    found = 1'b0;
    lvl   = '0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = LW'(low + LW'(1) + LW'(k));
      if (vec[idx]) begin
        found = 1'b1;
        lvl   = idx;
      end
    end
    rank = LW'(lvl - low - LW'(1));
  end
endmodule

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          rot_upd,
  input  logic [LW-1:0] rot_lvl,
  output pic_sched_e    sched,
  output logic [N-1:0]  mask,
  output logic [LW-1:0] low,
  output logic [DW-LW-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sched <= SCH_FIXED;
      mask  <= '0;
      low   <= LW'(N - 1);
      base  <= '0;
    end else begin
      if (we && addr == REG_SCHED) sched <= pic_sched_e'(wdata[1:0]);
      if (we && addr == REG_MASK)  mask  <= wdata[N-1:0];
      if (we && addr == REG_BASE)  base  <= wdata[DW-1:LW];
      if (we && addr == REG_LOW)   low   <= wdata[LW-1:0];
      else if (rot_upd)            low   <= rot_lvl;
    end
  end

  // R3
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == REG_MASK) |=> (mask == $past(wdata[N-1:0])));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_req,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          ack,
  input  logic          eoi,
  input  logic          poll_rd,
  output logic          irq_out,
  output logic [DW-1:0] vec_out,
  output logic [DW-1:0] poll_status
);
  localparam int LW = $clog2(N);

  pic_sched_e       sched;
  logic [N-1:0]     mask, pend_q, isr_q, eff;
  logic [LW-1:0]    low, ord_low;
  logic [DW-LW-1:0] base;
  logic             p_found, i_found, take, eoi_hit;
  logic [LW-1:0]    p_lvl, p_rank, i_lvl, i_rank;
  logic [N-1:0]     take_oh, eoi_oh;

  pic_cfg #(.N(N), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rot_upd(eoi_hit && sched == SCH_ROTATE), .rot_lvl(i_lvl),
    .sched(sched), .mask(mask), .low(low), .base(base)
  );

  // Fixed and polled schemes rank from level 0; others use the bottom register.
  assign ord_low = (sched == SCH_ROTATE || sched == SCH_BOTTOM) ? low : LW'(N - 1);
  assign eff     = pend_q & ~mask;

  pic_pick #(.N(N)) u_pend_pick (
    .vec(eff), .low(ord_low), .found(p_found), .lvl(p_lvl), .rank(p_rank));
  pic_pick #(.N(N)) u_isr_pick (
    .vec(isr_q), .low(ord_low), .found(i_found), .lvl(i_lvl), .rank(i_rank));

  assign irq_out = (sched != SCH_POLLED) && p_found && (!i_found || p_rank < i_rank);

  assign vec_out     = {base, irq_out ? p_lvl : LW'(N - 1)};
  assign poll_status = {p_found, {(DW-LW-1){1'b0}}, p_lvl};

  assign take    = (ack && irq_out) || (poll_rd && p_found);
  assign eoi_hit = eoi && i_found;
  assign take_oh = take    ? (N'(1) << p_lvl) : '0;
  assign eoi_oh  = eoi_hit ? (N'(1) << i_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~take_oh) | irq_req;
      isr_q  <= (isr_q & ~eoi_oh) | take_oh;
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != '0) |=> ((pend_q & $past(irq_req)) == $past(irq_req)));

  // R5
  ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> isr_q[$past(p_lvl)]);

  // R6
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !take && isr_q != '0) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  // R9
  poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == REG_SCHED && cfg_wdata[1:0] == 2'd3) |=> !irq_out);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic ack = 1'b0, eoi = 1'b0, poll_rd = 1'b0;
  logic irq_out;
  logic [7:0] vec_out, poll_status;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  bit done = 1'b0;

  logic [7:0] m_pend, m_isr, m_mask;
  logic [1:0] m_mode;
  logic [2:0] m_low;
  logic [4:0] m_base;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ack(ack), .eoi(eoi),
    .poll_rd(poll_rd), .irq_out(irq_out), .vec_out(vec_out),
    .poll_status(poll_status)
  );

  function automatic logic [3:0] pick(input logic [7:0] v, input logic [2:0] lo);
    logic [3:0] r;
    logic [2:0] idx;
    r = 4'd0;
    for (int k = 7; k >= 0; k--) begin
      idx = lo + 3'd1 + 3'(k);
      if (v[idx]) r = {1'b1, idx};
    end
    return r;
  endfunction

  function automatic logic [2:0] rank_of(input logic [2:0] l, input logic [2:0] lo);
    return l - lo - 3'd1;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [7:0] rq, input logic a, input logic e, input logic p,
                     input logic w, input logic [1:0] ad, input logic [7:0] wd,
                     input string tag);
    logic [2:0] ordl;
    logic [3:0] pw, pi;
    logic [7:0] eff, oh, eclr;
    logic exp_irq, take;
    @(negedge clk);
    irq_req = rq; ack = a; eoi = e; poll_rd = p;
    cfg_we = w; cfg_addr = ad; cfg_wdata = wd;
    #1;
    ordl = (m_mode == 2'd1 || m_mode == 2'd2) ? m_low : 3'd7;
    eff  = m_pend & ~m_mask;
    pw = pick(eff, ordl);
    pi = pick(m_isr, ordl);
    exp_irq = (m_mode != 2'd3) && pw[3] &&
              (!pi[3] || rank_of(pw[2:0], ordl) < rank_of(pi[2:0], ordl));
    chk({tag, " irq_out"}, {7'd0, irq_out}, {7'd0, exp_irq});
    if (a) chk({tag, " vec_out"}, vec_out, {m_base, exp_irq ? pw[2:0] : 3'd7});
    if (p) chk({tag, " poll_status"}, poll_status, {pw[3], 4'd0, pw[2:0]});
    take = (a && exp_irq) || (p && pw[3]);
    oh   = take ? (8'd1 << pw[2:0]) : 8'd0;
    eclr = (e && pi[3]) ? (8'd1 << pi[2:0]) : 8'd0;
    if (e && pi[3] && m_mode == 2'd1) m_low = pi[2:0];
    m_pend = (m_pend & ~oh) | rq;
    m_isr  = (m_isr & ~eclr) | oh;
    if (w) begin
      case (ad)
        2'd0: m_mode = wd[1:0];
        2'd1: m_mask = wd;
        2'd2: m_low  = wd[2:0];
        default: m_base = wd[7:3];
      endcase
    end
  endtask

  task automatic idle(input string tag);
    cyc(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, tag);
  endtask
  task automatic wr(input logic [1:0] ad, input logic [7:0] wd, input string tag);
    cyc(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, ad, wd, tag);
  endtask
  task automatic do_ack(input string tag);
    cyc(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, tag);
  endtask
  task automatic do_eoi(input string tag);
    cyc(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, tag);
  endtask
  task automatic do_poll(input string tag);
    cyc(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00, tag);
  endtask
  task automatic req(input logic [7:0] rq, input string tag);
    cyc(rq, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, tag);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 200000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", n_cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    m_pend = '0; m_isr = '0; m_mask = '0; m_mode = '0; m_low = 3'd7; m_base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state seen at the ports
    idle("R1");
    cyc(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, "R1");
    do_poll("R1");

    // R2 / R11: one-cycle requests on levels 2 and 5, fixed order
    req(8'h24, "R11");
    idle("R2");
    idle("R11");
    do_ack("R2");
    // R4: level 5 is blocked while level 2 is in service
    idle("R4");
    do_eoi("R6");
    idle("R4");
    do_ack("R5");
    do_eoi("R6");

    // R3: masked level 0 neither interrupts nor polls
    wr(2'd1, 8'h01, "R3");
    req(8'h01, "R3");
    idle("R3");
    do_poll("R3");
    wr(2'd1, 8'h00, "R3");
    idle("R3");
    // R5: vector base
    wr(2'd3, 8'hA8, "R5");
    do_ack("R5");
    do_eoi("R6");

    // R7: rotate-on-service
    wr(2'd0, 8'h01, "R7");
    req(8'h01, "R7");
    do_ack("R7");
    do_eoi("R7");
    req(8'h09, "R7");
    idle("R7");
    do_ack("R7");
    do_eoi("R7");
    do_ack("R7");
    do_eoi("R7");

    // R8: software-chosen bottom level 4 => level 5 highest
    wr(2'd0, 8'h02, "R8");
    wr(2'd2, 8'h04, "R8");
    req(8'h48, "R8");
    do_ack("R8");
    do_eoi("R8");
    // R10: switch to fixed with level 3 outstanding
    wr(2'd0, 8'h00, "R10");
    req(8'h80, "R10");
    do_ack("R10");
    do_eoi("R10");
    do_ack("R10");
    do_eoi("R10");

    // R9: polled scheme
    wr(2'd0, 8'h03, "R9");
    req(8'h10, "R9");
    idle("R9");
    do_poll("R9");
    do_poll("R9");
    do_eoi("R9");

    // R10: seeded random traffic with run-time scheme changes
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] rq, wd;
      logic a, e, p, w;
      rq = ($urandom % 4 == 0) ? 8'($urandom & $urandom) : 8'h00;
      a  = ($urandom % 3 == 0);
      e  = ($urandom % 5 == 0);
      p  = !a && ($urandom % 10 == 0);
      w  = ($urandom % 16 == 0);
      wd = 8'($urandom);
      if (w && ($urandom % 2 == 0)) wd = wd & 8'($urandom) & 8'($urandom);
      cyc(rq, a, e, p, w, 2'($urandom), wd, "R10");
    end

    finish_run();
  end
endmodule